// File: doc/BRIEF.md
# Interrupt CPU Interface

This block is the processor-facing half of a small interrupt controller. It takes the raw level of every interrupt line, along with a per-line enable, a per-line trigger mode and a per-line 8-bit priority, from the distribution logic. It keeps a pending bit and an active bit for each line. From the lines that are pending, enabled, not yet active and urgent enough, it picks one winner and raises a single interrupt request towards the processor.

Software talks to the block over a simple register port with one-cycle strobes. The register set has:
- an enable bit;
- a priority threshold;
- a group split setting;
- an acknowledge register, whose read takes the winning line and makes it active;
- an end-of-interrupt register, whose write retires an active line;
- two read-only views: the running priority and the best pending line.

A lower priority value is more urgent. Lines that are active can nest: a newly pending line can only break in when its group priority is strictly more urgent than the most urgent active one.

Top module: `irq_cpu_if`

## Requirements
- R1: Bit 0 of the control register (offset 0x00, reset 0) enables the interface. While it is 0, `irq_o` stays low and an acknowledge read returns 1023 without changing any line.
- R2: The threshold register (offset 0x04, bits [7:0], reset 0x00) allows a line to be signalled only when its priority is numerically below the threshold.
- R3: The group split register (offset 0x08, bits [2:0], reset 3) treats any write below 3 as 3 and reads back the value in use. A value b keeps priority bits [7:b+1] as the group, so b = 3 uses bits [7:4] and b = 7 puts every priority in group 0.
- R4: A read of offset 0x0C returns the winning line ID in `reg_rdata[9:0]` on the cycle after the read strobe. The same read clears that line's pending bit and sets its active bit.
- R5: When no line qualifies, the acknowledge read returns 1023 and leaves every pending and active bit unchanged.
- R6: The winner is the qualifying line with the numerically lowest priority. Among lines of equal priority, the lowest ID wins.
- R7: A pending line qualifies only if its group priority is strictly below the running priority.
- R8: The running priority (offset 0x14, bits [7:0]) reads 0xFF when no line is active. Otherwise it reads the lowest group priority among the active lines.
- R9: Writing a line ID to offset 0x10 (bits [9:0]) clears that line's active bit. If the named line is not active, the write changes nothing.
- R10: A line with its trigger bit at 1 becomes pending on a rising edge of its input only. A line with its trigger bit at 0 is pending while its input is high and it is not active; it drops its pending bit when the input falls, and it becomes pending again after being retired if the input is still high.
- R11: Offset 0x18 reads the ID of the most urgent line that is pending, enabled and not active, ignoring the threshold and the running priority. It reads 1023 when there is no such line.
- R12: `irq_o` is high one cycle after the interface is enabled and a qualifying line exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | N_LINES | Raw level of each interrupt line |
| line_en | input | N_LINES | Per-line enable from the distribution logic |
| line_edge | input | N_LINES | Trigger mode per line: 1 = rising edge, 0 = level |
| line_prio | input | N_LINES*8 | Priority of each line, 8 bits per line, line i at [8i+7:8i] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The checker watches four things on every cycle:
- that `irq_o` follows the enable bit and the qualifying-line signal;
- that an acknowledge adds exactly one active line and returns the winner;
- that a spurious acknowledge and an end-of-interrupt naming an idle line leave the active set alone;
- that the running priority is 0xFF whenever nothing is active.

Some behaviour can only be shown by the bench's scenarios:
- which line wins a tie;
- that an equal group priority does not preempt;
- how the group split changes the running priority;
- how edge and level lines differ after they are retired.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;

  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_THR  = 8'h04;
  localparam logic [7:0] OFS_SPLT = 8'h08;
  localparam logic [7:0] OFS_ACK  = 8'h0C;
  localparam logic [7:0] OFS_EOI  = 8'h10;
  localparam logic [7:0] OFS_RUN  = 8'h14;
  localparam logic [7:0] OFS_HPND = 8'h18;

  localparam logic [2:0] SPLIT_MIN = 3'd3;

  // Group part of a priority: bits above the split position are kept.
  function automatic logic [PRIO_W-1:0] grp_prio(input logic [PRIO_W-1:0] p,
                                                 input logic [2:0] split);
    logic [PRIO_W:0] keep;
    keep = {(PRIO_W+1){1'b1}} << (int'(split) + 1);
    return p & keep[PRIO_W-1:0];
  endfunction

  // Smallest split value honoured by the interface.
  function automatic logic [2:0] clamp_split(input logic [2:0] v);
    return (v < SPLIT_MIN) ? SPLIT_MIN : v;
  endfunction

endpackage

// File: rtl/irq_cpu_if_lines.sv
module irq_cpu_if_lines
  import irq_cpu_if_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] line_edge,
  input  logic [N_LINES-1:0] ack_hit,
  input  logic               eoi_req,
  input  logic [ID_W-1:0]    eoi_id,
  output logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] act,
  output logic [N_LINES-1:0] eoi_hit
);

  logic [N_LINES-1:0] line_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic rise;
    logic set_pend;

    assign rise       = line_in[i] & ~line_q[i];
    assign set_pend   = line_edge[i] ? rise : (line_in[i] & ~act[i]);
    assign eoi_hit[i] = eoi_req && (eoi_id == ID_W'(i)) && act[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[i] <= 1'b0;
        pend[i]   <= 1'b0;
        act[i]    <= 1'b0;
      end else begin
        line_q[i] <= line_in[i];

        if (ack_hit[i])
          pend[i] <= 1'b0;
        else if (set_pend)
          pend[i] <= 1'b1;
        else if (!line_edge[i] && !line_in[i])
          pend[i] <= 1'b0;

        if (ack_hit[i])
          act[i] <= 1'b1;
        else if (eoi_hit[i])
          act[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_cpu_if_arb.sv
module irq_cpu_if_arb
  import irq_cpu_if_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic [N_LINES-1:0]        pend,
  input  logic [N_LINES-1:0]        en,
  input  logic [N_LINES-1:0]        act,
  input  logic [N_LINES*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  input  logic [2:0]                split,
  output logic                      win_vld,
  output logic [ID_W-1:0]           win_id,
  output logic                      hp_vld,
  output logic [ID_W-1:0]           hp_id,
  output logic [PRIO_W-1:0]         run_prio
);

  always_comb begin
    logic [PRIO_W-1:0] win_best;
    logic [PRIO_W-1:0] hp_best;

    // Running priority: the most urgent group among the active lines.
    run_prio = '1;
    for (int i = 0; i < N_LINES; i++) begin
      if (act[i] && (grp_prio(prio[i*PRIO_W +: PRIO_W], split) < run_prio))
        run_prio = grp_prio(prio[i*PRIO_W +: PRIO_W], split);
    end

    // Strict comparison keeps the lowest ID when priorities are equal.
    win_vld  = 1'b0;
    win_id   = SPURIOUS_ID;
    win_best = '1;
    hp_vld   = 1'b0;
    hp_id    = SPURIOUS_ID;
    hp_best  = '1;
    for (int i = 0; i < N_LINES; i++) begin
      logic [PRIO_W-1:0] p;
      logic              cand;
      p    = prio[i*PRIO_W +: PRIO_W];
      cand = pend[i] && en[i] && !act[i];

      if (cand && (!hp_vld || (p < hp_best))) begin
        hp_vld  = 1'b1;
        hp_id   = ID_W'(i);
        hp_best = p;
      end

      if (cand && (p < thr) && (grp_prio(p, split) < run_prio) &&
          (!win_vld || (p < win_best))) begin
        win_vld  = 1'b1;
        win_id   = ID_W'(i);
        win_best = p;
      end
    end
  end

endmodule

// File: rtl/irq_cpu_if_regs.sv
module irq_cpu_if_regs
  import irq_cpu_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              win_vld,
  input  logic [ID_W-1:0]   win_id,
  input  logic              hp_vld,
  input  logic [ID_W-1:0]   hp_id,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              ctrl_en,
  output logic [PRIO_W-1:0] thr,
  output logic [2:0]        split,
  output logic              ack_fire,
  output logic              ack_take,
  output logic              eoi_req,
  output logic [ID_W-1:0]   eoi_id,
  output logic [31:0]       reg_rdata
);

  logic [ID_W-1:0] ack_id;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata[31:ID_W];

  assign ack_fire = reg_rd && (reg_addr == OFS_ACK);
  assign ack_take = ack_fire && ctrl_en && win_vld;
  assign ack_id   = ack_take ? win_id : SPURIOUS_ID;
  assign eoi_req  = reg_wr && (reg_addr == OFS_EOI);
  assign eoi_id   = reg_wdata[ID_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      thr     <= '0;
      split   <= SPLIT_MIN;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL: ctrl_en <= reg_wdata[0];
        OFS_THR:  thr     <= reg_wdata[PRIO_W-1:0];
        OFS_SPLT: split   <= clamp_split(reg_wdata[2:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {31'd0, ctrl_en};
        OFS_THR:  reg_rdata <= {24'd0, thr};
        OFS_SPLT: reg_rdata <= {29'd0, split};
        OFS_ACK:  reg_rdata <= {22'd0, ack_id};
        OFS_RUN:  reg_rdata <= {24'd0, run_prio};
        OFS_HPND: reg_rdata <= {22'd0, (hp_vld ? hp_id : SPURIOUS_ID)};
        default:  reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        line_in,
  input  logic [N_LINES-1:0]        line_en,
  input  logic [N_LINES-1:0]        line_edge,
  input  logic [N_LINES*PRIO_W-1:0] line_prio,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [7:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      irq_o
);

  // Named internal events, also watched by the checker.
  logic               ctrl_en;
  logic [PRIO_W-1:0]  thr;
  logic [2:0]         split;
  logic               ack_fire;
  logic               ack_take;
  logic               eoi_req;
  logic [ID_W-1:0]    eoi_id;
  logic [N_LINES-1:0] ack_hit;
  logic [N_LINES-1:0] eoi_hit;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] act;
  logic               win_vld;
  logic [ID_W-1:0]    win_id;
  logic               hp_vld;
  logic [ID_W-1:0]    hp_id;
  logic [PRIO_W-1:0]  run_prio;

  for (genvar i = 0; i < N_LINES; i++) begin : g_ack
    assign ack_hit[i] = ack_take && (win_id == ID_W'(i));
  end

  irq_cpu_if_lines #(.N_LINES(N_LINES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_edge (line_edge),
    .ack_hit   (ack_hit),
    .eoi_req   (eoi_req),
    .eoi_id    (eoi_id),
    .pend      (pend),
    .act       (act),
    .eoi_hit   (eoi_hit)
  );

  irq_cpu_if_arb #(.N_LINES(N_LINES)) u_arb (
    .pend     (pend),
    .en       (line_en),
    .act      (act),
    .prio     (line_prio),
    .thr      (thr),
    .split    (split),
    .win_vld  (win_vld),
    .win_id   (win_id),
    .hp_vld   (hp_vld),
    .hp_id    (hp_id),
    .run_prio (run_prio)
  );

  irq_cpu_if_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .win_vld   (win_vld),
    .win_id    (win_id),
    .hp_vld    (hp_vld),
    .hp_id     (hp_id),
    .run_prio  (run_prio),
    .ctrl_en   (ctrl_en),
    .thr       (thr),
    .split     (split),
    .ack_fire  (ack_fire),
    .ack_take  (ack_take),
    .eoi_req   (eoi_req),
    .eoi_id    (eoi_id),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= ctrl_en && win_vld;
  end

endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk
  import irq_cpu_if_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_en,
  input logic               irq_o,
  input logic               ack_fire,
  input logic               ack_take,
  input logic               win_vld,
  input logic [ID_W-1:0]    win_id,
  input logic               eoi_req,
  input logic [N_LINES-1:0] eoi_hit,
  input logic [N_LINES-1:0] ack_hit,
  input logic [N_LINES-1:0] act,
  input logic [PRIO_W-1:0]  run_prio,
  input logic [31:0]        reg_rdata
);

  // R1
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq_o);

  // R12
  irq_on_when_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && win_vld) |=> irq_o);

  // R4
  ack_returns_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (reg_rdata[ID_W-1:0] == $past(win_id)));

  // R4
  ack_adds_one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !(|eoi_hit)) |=> ($countones(act) == $countones($past(act)) + 1));

  // R5
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !ack_take && !eoi_req) |=>
      ((reg_rdata[ID_W-1:0] == SPURIOUS_ID) && (act == $past(act))));

  // R9
  eoi_idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !(|eoi_hit) && !ack_take) |=> (act == $past(act)));

  // R9
  eoi_retires_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eoi_hit) && !ack_take) |=> ($countones(act) + 1 == $countones($past(act))));

  // R8
  idle_running_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (run_prio == 8'hFF));

  // R4
  ack_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit));

endmodule

bind irq_cpu_if irq_cpu_if_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .irq_o     (irq_o),
  .ack_fire  (ack_fire),
  .ack_take  (ack_take),
  .win_vld   (win_vld),
  .win_id    (win_id),
  .eoi_req   (eoi_req),
  .eoi_hit   (eoi_hit),
  .ack_hit   (ack_hit),
  .act       (act),
  .run_prio  (run_prio),
  .reg_rdata (reg_rdata)
);

// File: tb/irq_cpu_if_tb.sv
module irq_cpu_if_tb;

  localparam int N = 32;
  localparam int SPUR = 1023;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line_in = '0;
  logic [N-1:0]  line_en = '1;
  logic [N-1:0]  line_edge = '0;
  logic [N*8-1:0] line_prio;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_o;

  logic [7:0] prio_a [N];

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) line_prio[i*8 +: 8] = prio_a[i];
  end

  irq_cpu_if #(.N_LINES(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_en   (line_en),
    .line_edge (line_edge),
    .line_prio (line_prio),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input int act_v, input int exp_v);
    n_tests++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input int exp_v);
    int d;
    rd(a, d);
    chk(tag, d, exp_v);
  endtask

  // Group priority restated: clear the low (split+1) bits.
  function automatic int grp(input int p, input int split);
    return (p >> (split + 1)) << (split + 1);
  endfunction

  task automatic t_reset();
    chk("R1 irq low after reset", int'(irq_o), 0);
    rd_chk("R1 ctrl reset", 8'h00, 0);
    rd_chk("R2 threshold reset", 8'h04, 0);
    rd_chk("R3 split reset", 8'h08, 3);
    rd_chk("R8 running idle", 8'h14, 8'hFF);
    rd_chk("R5 ack with nothing pending", 8'h0C, SPUR);
    rd_chk("R11 best pending none", 8'h18, SPUR);
  endtask

  task automatic t_setup();
    wr(8'h00, 1);
    wr(8'h04, 8'hF0);
    rd_chk("R2 threshold readback", 8'h04, 8'hF0);
    wr(8'h08, 1);
    rd_chk("R3 split clamps to 3", 8'h08, 3);
    wr(8'h08, 3);
  endtask

  task automatic t_mask();
    prio_a[5] = 8'hF0;
    line_in[5] = 1'b1;
    tick(3);
    chk("R2 prio equal to threshold not signalled", int'(irq_o), 0);
    rd_chk("R11 best pending ignores threshold", 8'h18, 5);
    rd_chk("R5 ack with masked line", 8'h0C, SPUR);
    prio_a[5] = 8'hEF;
    tick(3);
    chk("R2 prio below threshold signalled", int'(irq_o), 1);
    line_in[5] = 1'b0;
    tick(3);
    chk("R10 level pending drops with input", int'(irq_o), 0);
    rd_chk("R10 no pending after drop", 8'h18, SPUR);
    prio_a[5] = 8'h80;
  endtask

  task automatic t_enable();
    wr(8'h00, 0);
    line_in[3] = 1'b1;
    tick(3);
    chk("R1 disabled keeps irq low", int'(irq_o), 0);
    rd_chk("R1 disabled ack spurious", 8'h0C, SPUR);
    wr(8'h00, 1);
    tick(2);
    chk("R12 irq after enable", int'(irq_o), 1);
  endtask

  task automatic t_ack();
    rd_chk("R4 ack returns line 3", 8'h0C, 3);
    rd_chk("R8 running prio of line 3", 8'h14, grp(8'h80, 3));
    tick(1);
    chk("R4 pending cleared by ack", int'(irq_o), 0);
    rd_chk("R11 active line excluded", 8'h18, SPUR);
    wr(8'h10, 3);
    tick(3);
    chk("R10 level line re-pends after retire", int'(irq_o), 1);
    rd_chk("R4 second ack line 3", 8'h0C, 3);
    line_in[3] = 1'b0;
    wr(8'h10, 3);
    tick(3);
    rd_chk("R9 retire restores idle running", 8'h14, 8'hFF);
    chk("R9 irq low after retire", int'(irq_o), 0);
  endtask

  task automatic t_tie();
    prio_a[2] = 8'h60; prio_a[7] = 8'h40; prio_a[9] = 8'h40;
    line_in[2] = 1'b1; line_in[7] = 1'b1; line_in[9] = 1'b1;
    tick(3);
    rd_chk("R6 tie goes to lowest id", 8'h0C, 7);
    line_in[7] = 1'b0;
    rd_chk("R8 running 0x40", 8'h14, 8'h40);
    tick(1);
    chk("R7 equal group does not preempt", int'(irq_o), 0);
    rd_chk("R11 best pending ignores running", 8'h18, 9);
    rd_chk("R7 ack spurious under equal group", 8'h0C, SPUR);
    wr(8'h10, 7);
    rd_chk("R6 next winner 9", 8'h0C, 9);
    line_in[9] = 1'b0;
    wr(8'h10, 9);
    rd_chk("R6 lower urgency line last", 8'h0C, 2);
    line_in[2] = 1'b0;
    wr(8'h10, 2);
    rd_chk("R8 idle after tie test", 8'h14, 8'hFF);
    prio_a[2] = 8'h80; prio_a[7] = 8'h80; prio_a[9] = 8'h80;
  endtask

  task automatic t_preempt();
    prio_a[10] = 8'h80; prio_a[11] = 8'h50; prio_a[12] = 8'h58;
    line_in[10] = 1'b1;
    tick(3);
    rd_chk("R4 ack line 10", 8'h0C, 10);
    line_in[10] = 1'b0;
    line_in[11] = 1'b1;
    tick(3);
    chk("R7 more urgent group preempts", int'(irq_o), 1);
    rd_chk("R7 ack nested line 11", 8'h0C, 11);
    line_in[11] = 1'b0;
    rd_chk("R8 running follows nested line", 8'h14, grp(8'h50, 3));
    line_in[12] = 1'b1;
    tick(3);
    chk("R7 same group 0x58 vs 0x50 blocked", int'(irq_o), 0);
    wr(8'h08, 7);
    rd_chk("R3 split 7 gives group zero", 8'h14, grp(8'h50, 7));
    wr(8'h08, 3);
    wr(8'h10, 20);
    rd_chk("R9 retire of idle line ignored", 8'h14, 8'h50);
    wr(8'h10, 11);
    rd_chk("R9 retire line 11", 8'h14, 8'h80);
    tick(2);
    chk("R7 line 12 preempts 0x80", int'(irq_o), 1);
    rd_chk("R7 ack line 12", 8'h0C, 12);
    line_in[12] = 1'b0;
    wr(8'h10, 12);
    wr(8'h10, 10);
    rd_chk("R8 idle after preempt test", 8'h14, 8'hFF);
    prio_a[11] = 8'h80; prio_a[12] = 8'h80;
  endtask

  task automatic t_edge();
    line_edge[15] = 1'b1;
    line_in[15] = 1'b1;
    tick(3);
    rd_chk("R10 edge line pends on rise", 8'h0C, 15);
    wr(8'h10, 15);
    tick(3);
    chk("R10 held edge line no re-pend", int'(irq_o), 0);
    rd_chk("R10 ack spurious after edge retire", 8'h0C, SPUR);
    line_in[15] = 1'b0;
    tick(1);
    line_in[15] = 1'b1;
    tick(3);
    chk("R10 new rise pends again", int'(irq_o), 1);
    rd_chk("R10 ack second edge", 8'h0C, 15);
    wr(8'h10, 15);
    line_in[15] = 1'b0;
    line_edge[15] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) prio_a[i] = 8'h80;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_setup();
    t_mask();
    t_enable();
    t_ack();
    t_tie();
    t_preempt();
    t_edge();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule